// File: doc/BRIEF.md
# PCI Configuration Status and Identification Registers

This block keeps the sticky error and status flags that software reads from the upper half of the PCI configuration dword at offset 0x04. It also returns the fixed identification dword at offset 0x08. The PCI master and target engines report events as single-cycle strobes. Each strobe comes with the qualifiers it needs, such as whether this device mastered the transfer or whether the cycle was a special cycle. A qualified strobe sets its flag on the next clock edge, and the flag then stays set.

Software reads and writes through a simple port addressed by configuration byte offset. Read data is combinational from the address. A write to offset 0x04 clears every flag whose data bit is one, and leaves flags alone where the data bit is zero. The parity-response enable from the command register arrives as a level input, and it gates only the master data-parity flag. The bus protocol engine, parity generation and the SERR#/PERR# pin drivers are outside this block.

Top module: `pci_cfg_status`

## Requirements
- R1: After a synchronous reset every flag is zero, so offset 0x04 reads 0x0200_0000.
- R2: The master data-parity flag (read bit 24) sets only when, in one cycle, the PERR strobe is high, this device mastered the transfer, and the parity-response enable is one.
- R3: The signalled-target-abort flag (bit 27) sets one cycle after the target side strobes a target-abort termination.
- R4: The received-target-abort flag (bit 28) sets one cycle after a master transaction is strobed as ended by target-abort.
- R5: The received-master-abort flag (bit 29) sets on a master-abort strobe, except when the special-cycle qualifier is high in the same cycle, in which case it does not change.
- R6: The signalled-system-error flag (bit 30) sets one cycle after the SERR strobe.
- R7: The detected-parity flag (bit 31) sets on the parity-detect strobe whatever the parity-response enable is.
- R8: A write to offset 0x04 clears each flag whose write-data bit is one, and leaves each flag unchanged whose bit is zero.
- R9: When a set strobe and a clearing write hit the same flag in one cycle, the flag ends up set.
- R10: Bits 26:25 of offset 0x04 always read 01 (medium decode), and writes do not change them.
- R11: Offset 0x08 always reads 0x0600_0003 (class 0x060000, revision 0x03), and writes do not change it.
- R12: Bits 23:0 of offset 0x04 and every other offset read zero. Writes to other offsets leave all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | 8 | Configuration byte offset of the access |
| cfg_wr | input | 1 | Write strobe for the current offset |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_addr (combinational) |
| par_resp_en | input | 1 | Parity-response enable from the command register |
| ev_perr | input | 1 | PERR# driven or observed on the current transfer |
| ev_is_master | input | 1 | This device mastered the current transfer |
| ev_sig_tabort | input | 1 | Target side ended a transaction with target-abort |
| ev_rcv_tabort | input | 1 | Master transaction ended by target-abort |
| ev_mst_abort | input | 1 | Master transaction ended by master-abort |
| ev_special_cyc | input | 1 | Qualifier: the aborted transaction was a special cycle |
| ev_serr | input | 1 | This device asserts SERR# |
| ev_par_det | input | 1 | A parity error was detected |

## Verification
A flag's set strobe and a software write-one-to-clear of that same flag can land in the same clock cycle. The stimulus table drives both at once for the detected-parity and master-abort flags. It also drives a master-abort clear together with a master-abort strobe that is qualified as a special cycle. The bench reads offset 0x04 after the edge and expects the flag set when the strobe was qualified and cleared when it was not. A random phase issues strobes and writes together on every cycle and compares each read against a bench model in which set takes priority.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int NFLAG  = 6;

    localparam logic [ADDR_W-1:0] OFF_STATUS = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_IDENT  = 8'h08;

    localparam logic [23:0] CLASS_CODE = 24'h060000;
    localparam logic [7:0]  REV_LEVEL  = 8'h03;
    localparam logic [1:0]  DEVSEL_MED = 2'b01;
    localparam int          DEVSEL_LSB = 25;

    // flag indices; their dword bit positions come from flag_pos()
    localparam int F_MDPAR = 0;
    localparam int F_STABT = 1;
    localparam int F_RTABT = 2;
    localparam int F_RMABT = 3;
    localparam int F_SYSER = 4;
    localparam int F_DTPAR = 5;

    typedef logic [NFLAG-1:0] flag_vec_t;

    typedef struct packed {
        logic perr;
        logic is_master;
        logic sig_tabort;
        logic rcv_tabort;
        logic mst_abort;
        logic special_cyc;
        logic serr;
        logic par_det;
    } pcs_evt_t;

    function automatic int flag_pos(input int idx);
        case (idx)
            F_MDPAR: return 24;
            F_STABT: return 27;
            F_RTABT: return 28;
            F_RMABT: return 29;
            F_SYSER: return 30;
            default: return 31;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input flag_vec_t f);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DEVSEL_LSB +: 2] = DEVSEL_MED;
        for (int i = 0; i < NFLAG; i++) begin
            w[flag_pos(i)] = f[i];
        end
        return w;
    endfunction

endpackage

// File: rtl/pcs_set_logic.sv
module pcs_set_logic
    import pcs_pkg::*;
(
    input  pcs_evt_t  evt,
    input  logic      par_resp_en,
    output flag_vec_t set_vec
);
    always_comb begin
        set_vec          = '0;
        set_vec[F_MDPAR] = evt.perr & evt.is_master & par_resp_en;
        set_vec[F_STABT] = evt.sig_tabort;
        set_vec[F_RTABT] = evt.rcv_tabort;
        set_vec[F_RMABT] = evt.mst_abort & ~evt.special_cyc;
        set_vec[F_SYSER] = evt.serr;
        set_vec[F_DTPAR] = evt.par_det;
    end
endmodule

// File: rtl/pcs_flag_bank.sv
module pcs_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags_q
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             flags_q[g] <= 1'b0;
            else if (set_vec[g]) flags_q[g] <= 1'b1;
            else if (clr_vec[g]) flags_q[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/pcs_read_mux.sv
module pcs_read_mux
    import pcs_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  flag_vec_t         flags,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        case (addr)
            OFF_STATUS: rdata = status_word(flags);
            OFF_IDENT:  rdata = {CLASS_CODE, REV_LEVEL};
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/pci_cfg_status.sv
module pci_cfg_status
    import pcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic              cfg_wr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              par_resp_en,
    input  logic              ev_perr,
    input  logic              ev_is_master,
    input  logic              ev_sig_tabort,
    input  logic              ev_rcv_tabort,
    input  logic              ev_mst_abort,
    input  logic              ev_special_cyc,
    input  logic              ev_serr,
    input  logic              ev_par_det
);
    pcs_evt_t  evt;
    flag_vec_t set_vec;
    flag_vec_t clr_vec;
    flag_vec_t flags_q;
    logic      wr_hit;
    logic      wdata_unused;

    assign evt = '{perr:        ev_perr,
                   is_master:   ev_is_master,
                   sig_tabort:  ev_sig_tabort,
                   rcv_tabort:  ev_rcv_tabort,
                   mst_abort:   ev_mst_abort,
                   special_cyc: ev_special_cyc,
                   serr:        ev_serr,
                   par_det:     ev_par_det};

    assign wr_hit       = cfg_wr && (cfg_addr == OFF_STATUS);
    assign wdata_unused = ^{cfg_wdata[26:25], cfg_wdata[23:0]};

    always_comb begin
        for (int i = 0; i < NFLAG; i++) begin
            clr_vec[i] = wr_hit & cfg_wdata[flag_pos(i)];
        end
    end

    pcs_set_logic u_set (
        .evt         (evt),
        .par_resp_en (par_resp_en),
        .set_vec     (set_vec)
    );

    pcs_flag_bank #(.N(NFLAG)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags_q (flags_q)
    );

    pcs_read_mux u_rd (
        .addr  (cfg_addr),
        .flags (flags_q),
        .rdata (cfg_rdata)
    );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker
    import pcs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic              cfg_wr,
    input logic [DATA_W-1:0] cfg_wdata,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              par_resp_en,
    input logic              ev_perr,
    input logic              ev_is_master,
    input logic              ev_sig_tabort,
    input logic              ev_rcv_tabort,
    input logic              ev_mst_abort,
    input logic              ev_special_cyc,
    input logic              ev_serr,
    input logic              ev_par_det,
    input flag_vec_t         flags_q
);
    logic st_wr;
    assign st_wr = cfg_wr && (cfg_addr == OFF_STATUS);

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> flags_q == '0); // R1
    AST_MDPAR_QUAL: assert property (@(posedge clk) disable iff (rst)
        $rose(flags_q[F_MDPAR]) |-> $past(ev_perr && ev_is_master && par_resp_en)); // R2
    AST_STABT_SET: assert property (@(posedge clk) disable iff (rst)
        ev_sig_tabort |=> flags_q[F_STABT]); // R3
    AST_RTABT_SET: assert property (@(posedge clk) disable iff (rst)
        ev_rcv_tabort |=> flags_q[F_RTABT]); // R4
    AST_RMABT_SET: assert property (@(posedge clk) disable iff (rst)
        ev_mst_abort && !ev_special_cyc |=> flags_q[F_RMABT]); // R5
    AST_RMABT_SPECIAL: assert property (@(posedge clk) disable iff (rst)
        !flags_q[F_RMABT] && ev_special_cyc |=> !flags_q[F_RMABT]); // R5
    AST_SYSER_SET: assert property (@(posedge clk) disable iff (rst)
        ev_serr |=> flags_q[F_SYSER]); // R6
    AST_DTPAR_SET: assert property (@(posedge clk) disable iff (rst)
        ev_par_det |=> flags_q[F_DTPAR]); // R7
    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst)
        st_wr && cfg_wdata[30] && !ev_serr |=> !flags_q[F_SYSER]); // R8
    AST_W1C_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(st_wr && cfg_wdata[31]) && !ev_par_det |=> $stable(flags_q[F_DTPAR])); // R8
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        st_wr && cfg_wdata[28] && ev_rcv_tabort |=> flags_q[F_RTABT]); // R9
    AST_DEVSEL_FIXED: assert property (@(posedge clk) disable iff (rst)
        cfg_addr == OFF_STATUS |-> cfg_rdata[26:25] == 2'b01); // R10
    AST_IDENT_FIXED: assert property (@(posedge clk) disable iff (rst)
        cfg_addr == OFF_IDENT |-> cfg_rdata == 32'h0600_0003); // R11
    AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (rst)
        cfg_addr != OFF_STATUS && cfg_addr != OFF_IDENT |-> cfg_rdata == '0); // R12
endmodule

bind pci_cfg_status pcs_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .cfg_addr       (cfg_addr),
    .cfg_wr         (cfg_wr),
    .cfg_wdata      (cfg_wdata),
    .cfg_rdata      (cfg_rdata),
    .par_resp_en    (par_resp_en),
    .ev_perr        (ev_perr),
    .ev_is_master   (ev_is_master),
    .ev_sig_tabort  (ev_sig_tabort),
    .ev_rcv_tabort  (ev_rcv_tabort),
    .ev_mst_abort   (ev_mst_abort),
    .ev_special_cyc (ev_special_cyc),
    .ev_serr        (ev_serr),
    .ev_par_det     (ev_par_det),
    .flags_q        (flags_q)
);

// File: tb/pci_cfg_status_tb.sv
module pci_cfg_status_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_addr = 8'h04;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        par_resp_en = 1'b0;
    // bit order: {par_det, serr, special, mst_abort, rcv_ta, sig_ta, is_master, perr}
    logic [7:0]  ev = '0;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    always #4 clk = ~clk;

    pci_cfg_status u_dut (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .par_resp_en(par_resp_en),
        .ev_perr(ev[0]), .ev_is_master(ev[1]), .ev_sig_tabort(ev[2]),
        .ev_rcv_tabort(ev[3]), .ev_mst_abort(ev[4]), .ev_special_cyc(ev[5]),
        .ev_serr(ev[6]), .ev_par_det(ev[7])
    );

    typedef struct packed {
        logic [7:0]  ev;
        logic        en;
        logic        wr;
        logic [15:0] whi;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{8'h03, 1'b0, 1'b0, 16'h0000, 16'h0200}, // R2 enable low
        '{8'h01, 1'b1, 1'b0, 16'h0000, 16'h0200}, // R2 not master
        '{8'h03, 1'b1, 1'b0, 16'h0000, 16'h0300}, // R2 all three
        '{8'h30, 1'b0, 1'b0, 16'h0000, 16'h0300}, // R5 special cycle
        '{8'h10, 1'b0, 1'b0, 16'h0000, 16'h2300}, // R5 master abort
        '{8'h04, 1'b0, 1'b0, 16'h0000, 16'h2B00}, // R3
        '{8'h08, 1'b0, 1'b0, 16'h0000, 16'h3B00}, // R4
        '{8'h40, 1'b0, 1'b0, 16'h0000, 16'h7B00}, // R6
        '{8'h80, 1'b0, 1'b0, 16'h0000, 16'hFB00}, // R7 enable low
        '{8'h00, 1'b0, 1'b1, 16'h0000, 16'hFB00}, // R8 zeros hold
        '{8'h00, 1'b0, 1'b1, 16'h0100, 16'hFA00}, // R8 clear one
        '{8'h00, 1'b0, 1'b1, 16'h0600, 16'hFA00}, // R10 devsel write
        '{8'h80, 1'b0, 1'b1, 16'h8000, 16'hFA00}, // R9 set beats clear
        '{8'h00, 1'b0, 1'b1, 16'hFF00, 16'h0200}, // R8 clear all
        '{8'h10, 1'b0, 1'b1, 16'h2000, 16'h2200}, // R9 master abort
        '{8'h30, 1'b0, 1'b1, 16'h2000, 16'h0200}  // R5 R9 special: clear wins
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic cyc(input logic [7:0] e, input logic en, input logic wr,
                       input logic [7:0] a, input logic [31:0] wd);
        ev = e; par_resp_en = en; cfg_wr = wr; cfg_addr = a; cfg_wdata = wd;
        @(negedge clk);
        ev = '0; cfg_wr = 1'b0;
    endtask

    function automatic logic [31:0] model_word(input logic [5:0] m);
        return {m[5], m[4], m[3], m[2], m[1], 2'b01, m[0], 24'h0};
    endfunction

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [5:0] m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cfg_addr = 8'h04;
        #1 chk("R1 reset status", cfg_rdata, 32'h0200_0000);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            cyc(TBL[i].ev, TBL[i].en, TBL[i].wr, 8'h04, {TBL[i].whi, 16'h0});
            chk($sformatf("TBL step %0d", i), cfg_rdata, {TBL[i].exp, 16'h0});
        end

        // R1: reset again with flags set
        cyc(8'hDC, 1'b0, 1'b0, 8'h04, 32'h0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 reset clears", cfg_rdata, 32'h0200_0000);

        // R11 identification word, write ignored
        cyc(8'h00, 1'b0, 1'b0, 8'h08, 32'h0);
        chk("R11 ident", cfg_rdata, 32'h0600_0003);
        cyc(8'h00, 1'b0, 1'b1, 8'h08, 32'hFFFF_FFFF);
        chk("R11 ident after write", cfg_rdata, 32'h0600_0003);

        // R12 low bits, R10 devsel
        cyc(8'h00, 1'b0, 1'b1, 8'h04, 32'h0000_FFFF);
        chk("R12 R10 low bits", cfg_rdata, 32'h0200_0000);

        // R12 writes elsewhere do not clear
        cyc(8'h40, 1'b0, 1'b0, 8'h04, 32'h0);
        cyc(8'h00, 1'b0, 1'b1, 8'h10, 32'hFFFF_FFFF);
        chk("R12 other offset read", cfg_rdata, 32'h0);
        cyc(8'h00, 1'b0, 1'b1, 8'h00, 32'hFFFF_FFFF);
        chk("R12 offset zero read", cfg_rdata, 32'h0);
        cfg_addr = 8'h04;
        #1 chk("R12 flag kept", cfg_rdata, 32'h4200_0000);
        @(negedge clk);

        // random phase against model: R2..R9
        m = 6'b010000;
        for (int k = 0; k < 400; k++) begin
            logic [7:0]  e;
            logic        en, wr;
            logic [31:0] wd;
            logic [5:0]  s, c;
            for (int b = 0; b < 8; b++) e[b] = ($urandom_range(0, 2) == 0);
            en = $urandom_range(0, 1) == 1;
            wr = $urandom_range(0, 1) == 1;
            wd = $urandom;
            s = {e[7], e[6], e[4] & ~e[5], e[3], e[2], e[0] & e[1] & en};
            c = wr ? {wd[31], wd[30], wd[29], wd[28], wd[27], wd[24]} : 6'b0;
            m = s | (m & ~c);
            cyc(e, en, wr, 8'h04, wd);
            chk("R8 R9 random model", cfg_rdata, model_word(m));
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule